// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and carries data across in either direction or in both at once. Each direction has three things of its own: a storage register clocked by its own capture clock, a source select, and an output enable. The source select decides whether the driven side carries the live value now present on the opposite bus or the word last captured in that direction's register. A capture edge loads its register whatever the selects and enables are doing. This lets software-free logic around the block snapshot a bus while it is sending something else.

The pins are modelled as separate input, output and output-enable vectors so that the block can be synthesized. External resolution of those vectors into real wires belongs to the chip. Two build-time parameters change the data path. `INVERT` complements both directions and both sources. `A_OPEN_DRAIN` turns the A-side drivers into pull-down-only drivers.

When both directions are enabled and both selects are live, each bus output copies the other bus, which in turn copies it. The two buses then keep their last values after every other driver lets go.

Top module: `rbx_regbus`

## Requirements
- R1: While `rst_n` is low, both storage registers read zero, so a direction whose select is high sends all zeros (all ones with `INVERT=1`).
- R2: A rising edge on `clk_a2b` loads the value present on `a_in` into the A-to-B register, and a rising edge on `clk_b2a` loads `b_in` into the B-to-A register. This happens at any setting of the enables and selects. Each clock leaves the other register unchanged.
- R3: A select at 0 sends the live input of the opposite bus (`a_in` to the B side, `b_in` to the A side).
- R4: A select at 1 sends the word held in that direction's register.
- R5: With `en_b` at 1, `b_oe` is all ones and `b_out` carries the A-to-B data. With `en_b` at 0, `b_oe` is all zeros.
- R6: With `en_a_n` at 0, the A side is driven with the B-to-A data. With `en_a_n` at 1, `a_oe` is all zeros.
- R7: With `INVERT=1`, every sent bit is the complement of its source, in both directions and for both the live and the stored source. The registers hold the bus value uncomplemented.
- R8: With `A_OPEN_DRAIN=1`, an `a_oe` bit is 1 only where the B-to-A data bit is 0, and `a_out` is 0 at that bit. Bits whose data is 1 are left undriven for the pull-up.
- R9: With both enables active and both selects at 0, after the external drivers release both buses, each bus keeps the value it had just before the release. Undriven bits are pulled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-to-B register |
| clk_b2a | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| en_b | input | 1 | Active-high drive enable for the B side |
| en_a_n | input | 1 | Active-low drive enable for the A side |
| sel_a2b | input | 1 | B-side source: 0 live A bus, 1 stored word |
| sel_b2a | input | 1 | A-side source: 0 live B bus, 1 stored word |
| a_in | input | WIDTH | Resolved value of the A bus |
| a_out | output | WIDTH | Value driven onto the A bus |
| a_oe | output | WIDTH | Per-bit drive enable for the A bus |
| b_in | input | WIDTH | Resolved value of the B bus |
| b_out | output | WIDTH | Value driven onto the B bus |
| b_oe | output | WIDTH | Per-bit drive enable for the B bus |

## Verification
A corrupted register shows up at the opposite bus on the same cycle that its direction is enabled with the stored source selected. Until then it stays hidden, so the bench captures words while the outputs are off and then sends them back out. A wrong select or enable decode shows at once as a changed enable vector or a wrong driven value. A broken loop between the directions shows only after the external drivers let go, so the bench reads both resolved buses after each release.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/rbx_hold_reg.sv
module rbx_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  // capture is unconditional: every rising edge loads the bus
  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q == $past(d))); // R2

endmodule

// File: rtl/rbx_path_sel.sv
module rbx_path_sel
  import rbx_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  src_sel_e         src,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] data
);

  logic [WIDTH-1:0] picked;

  always_comb begin
    picked = (src == SRC_STORED) ? stored : live;
  end

  generate
    if (INVERT) begin : g_inv
      assign data = ~picked;
    end else begin : g_true
      assign data = picked;
    end
  endgenerate

endmodule

// File: rtl/rbx_drive.sv
module rbx_drive #(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             en,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] oe
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (OPEN_DRAIN) begin : g_od
        assign oe[i]  = en & ~data[i];
        assign out[i] = 1'b0;
      end else begin : g_tri
        assign oe[i]  = en;
        assign out[i] = data[i];
      end
    end
  endgenerate

endmodule

// File: rtl/rbx_regbus.sv
module rbx_regbus
  import rbx_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter bit INVERT       = 1'b0,
  parameter bit A_OPEN_DRAIN = 1'b0
) (
  input  logic             clk_a2b,
  input  logic             clk_b2a,
  input  logic             rst_n,
  input  logic             en_b,
  input  logic             en_a_n,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  localparam logic [WIDTH-1:0] INV_MASK = {WIDTH{INVERT}};

  logic [WIDTH-1:0] held_a;
  logic [WIDTH-1:0] held_b;
  logic [WIDTH-1:0] path_ab;
  logic [WIDTH-1:0] path_ba;
  logic             drive_a;

  assign drive_a = ~en_a_n;

  rbx_hold_reg #(.WIDTH(WIDTH)) u_hold_a (
    .clk   (clk_a2b),
    .rst_n (rst_n),
    .d     (a_in),
    .q     (held_a)
  );

  rbx_hold_reg #(.WIDTH(WIDTH)) u_hold_b (
    .clk   (clk_b2a),
    .rst_n (rst_n),
    .d     (b_in),
    .q     (held_b)
  );

  rbx_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_ab (
    .src    (src_sel_e'(sel_a2b)),
    .live   (a_in),
    .stored (held_a),
    .data   (path_ab)
  );

  rbx_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_ba (
    .src    (src_sel_e'(sel_b2a)),
    .live   (b_in),
    .stored (held_b),
    .data   (path_ba)
  );

  rbx_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(1'b0)) u_drv_b (
    .en   (en_b),
    .data (path_ab),
    .out  (b_out),
    .oe   (b_oe)
  );

  rbx_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(A_OPEN_DRAIN)) u_drv_a (
    .en   (drive_a),
    .data (path_ba),
    .out  (a_out),
    .oe   (a_oe)
  );

  always_comb begin
    if (!en_b) begin
      AST_B_QUIET: assert (b_oe == '0); // R5
    end
    if (en_a_n) begin
      AST_A_QUIET: assert (a_oe == '0); // R6
    end
    if (en_b && !sel_a2b) begin
      AST_B_LIVE: assert (b_out == (a_in ^ INV_MASK)); // R3
    end
    if (A_OPEN_DRAIN) begin
      AST_A_PULL_LOW_ONLY: assert ((a_oe & a_out) == '0); // R8
    end
  end

  AST_B_STORED: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (en_b && sel_a2b) |=> (b_out == (held_a ^ INV_MASK))); // R4

endmodule

// File: tb/rbx_regbus_bench.sv
module rbx_regbus_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int  W          = 8;
  localparam time CLK_PERIOD = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic clk_a2b = 1'b0, clk_b2a = 1'b0, rst_n = 1'b0;
  logic en_b = 1'b1, en_a_n = 1'b0, sel_a2b = 1'b1, sel_b2a = 1'b1;
  logic ext_a_en = 1'b0, ext_b_en = 1'b0;
  logic [W-1:0] ext_a = '0, ext_b = '0;

  logic [W-1:0] a_bus [2];
  logic [W-1:0] b_bus [2];
  logic [W-1:0] a_out [2];
  logic [W-1:0] a_oe  [2];
  logic [W-1:0] b_out [2];
  logic [W-1:0] b_oe  [2];
  logic [W-1:0] st_a  [2];
  logic [W-1:0] st_b  [2];

  typedef struct {
    string      req;
    bit         kind;  // 0 drive vectors, 1 resolved buses
    int         k;
    logic [W-1:0] e1, e2, e3, e4;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial begin
    for (int k = 0; k < 2; k++) begin
      a_bus[k] = '1; b_bus[k] = '1; st_a[k] = '0; st_b[k] = '0;
    end
  end

  rbx_regbus #(.WIDTH(W), .INVERT(1'b0), .A_OPEN_DRAIN(1'b0)) u_rbx_regbus (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst_n(rst_n),
    .en_b(en_b), .en_a_n(en_a_n), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .a_in(a_bus[0]), .a_out(a_out[0]), .a_oe(a_oe[0]),
    .b_in(b_bus[0]), .b_out(b_out[0]), .b_oe(b_oe[0])
  );

  rbx_regbus #(.WIDTH(W), .INVERT(1'b1), .A_OPEN_DRAIN(1'b1)) u_rbx_regbus_alt (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst_n(rst_n),
    .en_b(en_b), .en_a_n(en_a_n), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .a_in(a_bus[1]), .a_out(a_out[1]), .a_oe(a_oe[1]),
    .b_in(b_bus[1]), .b_out(b_out[1]), .b_oe(b_oe[1])
  );

  // bus resolution: external driver wins, then the block, else pull-up
  task automatic settle();
    for (int n = 0; n < 4; n++) begin
      #1;
      for (int k = 0; k < 2; k++) begin
        a_bus[k] = ext_a_en ? ext_a : ((a_oe[k] & a_out[k]) | ~a_oe[k]);
        b_bus[k] = ext_b_en ? ext_b : ((b_oe[k] & b_out[k]) | ~b_oe[k]);
      end
    end
  endtask

  task automatic step(string req, bit pa, bit pb);
    item_t it;
    logic [W-1:0] inv, pab, pba;
    @(posedge clk);
    settle();
    if (pa || pb) begin
      for (int k = 0; k < 2; k++) begin
        if (pa) st_a[k] = a_bus[k];
        if (pb) st_b[k] = b_bus[k];
      end
      clk_a2b = pa; clk_b2a = pb;
      #1;
      clk_a2b = 1'b0; clk_b2a = 1'b0;
      settle();
    end
    for (int k = 0; k < 2; k++) begin
      inv = (k == 1) ? '1 : '0;
      pab = (sel_a2b ? st_a[k] : a_bus[k]) ^ inv;
      pba = (sel_b2a ? st_b[k] : b_bus[k]) ^ inv;
      it.req = req; it.kind = 1'b0; it.k = k;
      it.e3 = en_b ? '1 : '0;
      it.e4 = en_b ? pab : '0;
      if (en_a_n) begin
        it.e1 = '0; it.e2 = '0;
      end else if (k == 1) begin
        it.e1 = ~pba; it.e2 = '0;
      end else begin
        it.e1 = '1; it.e2 = pba;
      end
      sb_q.push_back(it);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic hold_check(string req, logic [W-1:0] a0, logic [W-1:0] b0,
                            logic [W-1:0] a1, logic [W-1:0] b1);
    item_t it;
    it.req = req; it.kind = 1'b1;
    it.k = 0; it.e1 = a0; it.e2 = b0; it.e3 = '0; it.e4 = '0;
    sb_q.push_back(it);
    it.k = 1; it.e1 = a1; it.e2 = b1;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin : monitor
    item_t it;
    logic [W-1:0] g1, g2, g3, g4;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        total++;
        if (it.kind) begin
          if (a_bus[it.k] !== it.e1 || b_bus[it.k] !== it.e2) begin
            bad++;
            $display("FAIL %s inst%0d: buses a=%h b=%h, expected a=%h b=%h",
                     it.req, it.k, a_bus[it.k], b_bus[it.k], it.e1, it.e2);
          end
        end else begin
          g1 = a_oe[it.k]; g2 = a_out[it.k] & a_oe[it.k];
          g3 = b_oe[it.k]; g4 = b_out[it.k] & b_oe[it.k];
          if (g1 !== it.e1 || g2 !== it.e2 || g3 !== it.e3 || g4 !== it.e4) begin
            bad++;
            $display("FAIL %s inst%0d: a_oe=%h a_val=%h b_oe=%h b_val=%h, expected %h %h %h %h",
                     it.req, it.k, g1, g2, g3, g4, it.e1, it.e2, it.e3, it.e4);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    // R1: registers cleared while reset is held, stored source on both sides
    step("R1 reset clears both registers", 1'b0, 1'b0);
    rst_n = 1'b1; en_b = 1'b0; en_a_n = 1'b1;

    // R3 R5 R7: live A to B
    ext_a_en = 1'b1; ext_a = 8'h3C; en_b = 1'b1; sel_a2b = 1'b0;
    step("R3 R5 R7 live A to B", 1'b0, 1'b0);

    // R3 R6 R8: live B to A
    ext_a_en = 1'b0; en_b = 1'b0; ext_b_en = 1'b1; ext_b = 8'hA5;
    en_a_n = 1'b0; sel_b2a = 1'b0;
    step("R3 R6 R8 live B to A", 1'b0, 1'b0);

    // R2 R5 R6: store only, outputs off
    en_a_n = 1'b1; ext_a_en = 1'b1; ext_a = 8'h96; ext_b = 8'h69;
    step("R2 R5 R6 store with outputs off", 1'b1, 1'b1);

    // R4 R7: stored word A to B
    ext_b_en = 1'b0; ext_a = 8'h11; en_b = 1'b1; sel_a2b = 1'b1;
    step("R4 R7 stored A to B", 1'b0, 1'b0);

    // R4 R8: stored word B to A
    en_b = 1'b0; ext_a_en = 1'b0; ext_b_en = 1'b1; ext_b = 8'h22;
    en_a_n = 1'b0; sel_b2a = 1'b1;
    step("R4 R8 stored B to A", 1'b0, 1'b0);

    // R2: B clock reloads only the B-to-A register
    ext_b = 8'hF0;
    step("R2 B clock reloads B register", 1'b0, 1'b1);
    en_a_n = 1'b1; ext_b_en = 1'b0; ext_a_en = 1'b1; ext_a = 8'h0F;
    en_b = 1'b1; sel_a2b = 1'b1;
    step("R2 A register untouched by B clock", 1'b0, 1'b0);

    // R2: capture while stored source is being sent
    ext_a = 8'hC3;
    step("R2 capture while enabled", 1'b1, 1'b0);

    // R9: loop driven from A, then released
    sel_a2b = 1'b0; sel_b2a = 1'b0; en_a_n = 1'b0; ext_a = 8'h5A;
    step("R9 loop driven from A", 1'b0, 1'b0);
    ext_a_en = 1'b0;
    step("R9 loop after A release", 1'b0, 1'b0);
    hold_check("R9 buses hold after A release", 8'h5A, 8'h5A, 8'h5A, 8'hA5);

    // R9: loop driven from B, then released
    ext_b_en = 1'b1; ext_b = 8'hC6;
    step("R9 loop driven from B", 1'b0, 1'b0);
    ext_b_en = 1'b0;
    step("R9 loop after B release", 1'b0, 1'b0);
    hold_check("R9 buses hold after B release", 8'hC6, 8'hC6, 8'h39, 8'hC6);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule